// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when a successive-approximation converter samples its input and converts it. Software writes a start bit, a sync-mode bit and an input-select field over a serial register bus. Those values reach the block once per bus frame, marked by a single-cycle frame strobe. An external sync pin, which is asynchronous to the block clock, can also trigger a conversion. The block drives the track-and-hold control and one strobe for each of the calibration and conversion phases. The converter core is treated as a fixed-length busy phase. When the result is complete, the block raises a data-valid flag.

There are two ways to start. With sync mode off, a 0-to-1 change of the start bit between two frame strobes launches a timed track, calibrate and convert sequence. With sync mode on, the same change only arms the block. The track-and-hold then follows the input until a rising edge on the sync pin starts calibration and conversion. In either mode, if the input selection changed in the frame that carried the start request, an extra settling interval is added first. Sync edges that fall inside that interval are discarded.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `track_o`, `cal_o`, `conv_o` and `data_valid` are all 0.
- R2: With `sync_mode`=0, an accepted start puts `track_o` high for TRACK_CYC cycles, starting with the first clock edge after the strobe. `cal_o` then follows for CAL_CYC cycles and `conv_o` for CONV_CYC cycles. At most one of the three outputs is high at any time.
- R3: A start request is accepted on a `frame_stb` cycle when `start_bit` is 1 and was 0 at the previous strobe. If `in_sel` also differs from its value at the previous strobe, SETTLE_CYC extra tracking cycles come before the track phase or the armed wait. Both stored values reset to 0.
- R4: The following cause no start: `start_bit` changing without a strobe, `start_bit` staying 1 across strobes, and start edges that arrive while a sequence is running.
- R5: With `sync_mode`=1, an accepted start arms the block. `track_o` stays high and `cal_o` stays low for as long as no sync edge is seen.
- R6: In the armed state, a rising edge on `sync_pin` first passes a two-flop synchronizer. `cal_o` rises at the third clock edge after the pin goes high. The CAL_CYC and CONV_CYC phases follow.
- R7: Rising edges of `sync_pin` during the settling interval are ignored. The first edge after the interval starts the sequence.
- R8: `data_valid` clears at the edge that accepts a start. It sets when the conversion phase ends and holds until the next accepted start.
- R9: `adc_en`=0 returns the block to idle at the next edge from any state, including an armed wait. No start is accepted while `adc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Converter enable; 0 forces idle |
| frame_stb | input | 1 | One-cycle strobe marking a new bus frame |
| start_bit | input | 1 | Start request register bit |
| sync_mode | input | 1 | 0: start on start-bit edge; 1: arm and wait for sync pin |
| in_sel | input | SEL_W | Input multiplexer selection |
| sync_pin | input | 1 | Asynchronous external sync input |
| track_o | output | 1 | Track-and-hold in track mode |
| cal_o | output | 1 | Calibration phase active |
| conv_o | output | 1 | Conversion phase active |
| data_valid | output | 1 | Result of last sequence complete |

## Verification
The case that is hardest to reach from the ports is a sync edge that arrives while the block is still settling. To get there, the start frame must change the selection relative to the previous frame, sync mode must be on, and the pin must rise within the few cycles after the strobe. The stimulus builds exactly that frame pair, raises the pin at once and holds it high past the settling interval, then checks that the block is still armed. A fresh edge is then required. Randomized runs vary the selection pair, and the delay before the pin rises, in both modes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_ARMED,
        PH_TRACK,
        PH_CAL,
        PH_CONV
    } phase_e;

    typedef struct packed {
        logic start_req;
        logic sel_chg;
    } frame_evt_t;

    typedef struct packed {
        logic track;
        logic cal;
        logic conv;
    } phase_out_t;

    function automatic phase_out_t decode_phase(phase_e p);
        phase_out_t o;
        o.track = (p == PH_SETTLE) || (p == PH_ARMED) || (p == PH_TRACK);
        o.cal   = (p == PH_CAL);
        o.conv  = (p == PH_CONV);
        return o;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/adc_seq_sync_edge.sv
module adc_seq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/adc_seq_frame_track.sv
module adc_seq_frame_track
    import adc_seq_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic             start_bit,
    input  logic [SEL_W-1:0] in_sel,
    output frame_evt_t       evt
);
    logic             start_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            sel_q   <= '0;
        end else if (frame_stb) begin
            start_q <= start_bit;
            sel_q   <= in_sel;
        end
    end

    always_comb begin
        evt.start_req = frame_stb & start_bit & ~start_q;
        evt.sel_chg   = frame_stb & (in_sel != sel_q);
    end
endmodule

// File: rtl/adc_seq_phase_fsm.sv
module adc_seq_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CYC  = 16,
    parameter int CAL_CYC    = 8,
    parameter int CONV_CYC   = 12,
    parameter int SETTLE_CYC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adc_en,
    input  logic       sync_mode,
    input  frame_evt_t evt,
    input  logic       sync_rise,
    output phase_out_t ph_out,
    output logic       valid
);
    localparam int MAXC = max4(TRACK_CYC, CAL_CYC, CONV_CYC, SETTLE_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] TRACK_LD  = CNT_W'(TRACK_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LD    = CNT_W'(CAL_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD   = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

    phase_e           ph;
    logic [CNT_W-1:0] cnt;
    logic             mode_q;
    logic             cnt_done;

    assign cnt_done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
            valid  <= 1'b0;
        end else if (!adc_en) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (evt.start_req) begin
                        valid  <= 1'b0;
                        mode_q <= sync_mode;
                        if (evt.sel_chg) begin
                            ph  <= PH_SETTLE;
                            cnt <= SETTLE_LD;
                        end else if (sync_mode) begin
                            ph <= PH_ARMED;
                        end else begin
                            ph  <= PH_TRACK;
                            cnt <= TRACK_LD;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (cnt_done) begin
                        ph  <= mode_q ? PH_ARMED : PH_TRACK;
                        cnt <= TRACK_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ARMED: begin
                    if (sync_rise) begin
                        ph  <= PH_CAL;
                        cnt <= CAL_LD;
                    end
                end
                PH_TRACK: begin
                    if (cnt_done) begin
                        ph  <= PH_CAL;
                        cnt <= CAL_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CAL: begin
                    if (cnt_done) begin
                        ph  <= PH_CONV;
                        cnt <= CONV_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt_done) begin
                        ph    <= PH_IDLE;
                        valid <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign ph_out = decode_phase(ph);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
    import adc_seq_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int TRACK_CYC   = 16,
    parameter int CAL_CYC     = 8,
    parameter int CONV_CYC    = 12,
    parameter int SETTLE_CYC  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adc_en,
    input  logic             frame_stb,
    input  logic             start_bit,
    input  logic             sync_mode,
    input  logic [SEL_W-1:0] in_sel,
    input  logic             sync_pin,
    output logic             track_o,
    output logic             cal_o,
    output logic             conv_o,
    output logic             data_valid
);
    frame_evt_t evt;
    phase_out_t ph_out;
    logic       sync_rise;

    adc_seq_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .pin  (sync_pin),
        .rise (sync_rise)
    );

    adc_seq_frame_track #(.SEL_W(SEL_W)) frame_i (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .start_bit (start_bit),
        .in_sel    (in_sel),
        .evt       (evt)
    );

    adc_seq_phase_fsm #(
        .TRACK_CYC  (TRACK_CYC),
        .CAL_CYC    (CAL_CYC),
        .CONV_CYC   (CONV_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .adc_en    (adc_en),
        .sync_mode (sync_mode),
        .evt       (evt),
        .sync_rise (sync_rise),
        .ph_out    (ph_out),
        .valid     (data_valid)
    );

    assign track_o = ph_out.track;
    assign cal_o   = ph_out.cal;
    assign conv_o  = ph_out.conv;
endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk (
    input logic clk,
    input logic rst,
    input logic adc_en,
    input logic track_o,
    input logic cal_o,
    input logic conv_o,
    input logic data_valid
);
    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({track_o, cal_o, conv_o}));

    p_cal_after_track_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_o) |-> $past(track_o));

    p_conv_after_cal_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> $past(cal_o));

    p_valid_after_conv_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(conv_o));

    p_valid_clear_on_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(track_o) |-> !data_valid);

    p_disable_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !adc_en |=> (!track_o && !cal_o && !conv_o));
endmodule

bind adc_start_seq adc_start_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .adc_en     (adc_en),
    .track_o    (track_o),
    .cal_o      (cal_o),
    .conv_o     (conv_o),
    .data_valid (data_valid)
);

// File: tb/adc_start_seq_tb_top.sv
module adc_start_seq_tb_top;
    localparam int TR = 16;
    localparam int CA = 8;
    localparam int CV = 12;
    localparam int ST = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_en = 1'b0;
    logic       frame_stb = 1'b0;
    logic       start_bit = 1'b0;
    logic       sync_mode = 1'b0;
    logic [2:0] in_sel = 3'd0;
    logic       sync_pin = 1'b0;
    logic       track_o, cal_o, conv_o, data_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    adc_start_seq #(
        .SEL_W(3), .SYNC_STAGES(2), .TRACK_CYC(TR), .CAL_CYC(CA),
        .CONV_CYC(CV), .SETTLE_CYC(ST)
    ) dut_i (
        .clk(clk), .rst(rst), .adc_en(adc_en), .frame_stb(frame_stb),
        .start_bit(start_bit), .sync_mode(sync_mode), .in_sel(in_sel),
        .sync_pin(sync_pin), .track_o(track_o), .cal_o(cal_o),
        .conv_o(conv_o), .data_valid(data_valid)
    );

    function automatic int exp_track(bit chg);
        return TR + (chg ? ST : 0);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frame(bit sb, logic [2:0] sel, bit mode);
        start_bit = sb;
        in_sel    = sel;
        sync_mode = mode;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic run_len(output int t, output int c, output int v);
        t = 0; c = 0; v = 0;
        while (track_o && t < 1000) begin t++; @(negedge clk); end
        while (cal_o && c < 1000) begin c++; @(negedge clk); end
        while (conv_o && v < 1000) begin v++; @(negedge clk); end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t, c, v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        adc_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {track_o, cal_o, conv_o, data_valid}, 0);

        // R2/R3/R8 random software starts
        for (int i = 0; i < 30; i++) begin
            logic [2:0] sa, sb;
            bit chg;
            sa = 3'($urandom % 8);
            sb = ($urandom % 2) ? sa : 3'($urandom % 8);
            chg = (sa != sb);
            frame(1'b0, sa, 1'b0);
            frame(1'b1, sb, 1'b0);
            chk("R8 valid cleared", data_valid, 0);
            run_len(t, c, v);
            chk("R3 track length", t, exp_track(chg));
            chk("R2 cal length", c, CA);
            chk("R2 conv length", v, CV);
            chk("R8 valid set", data_valid, 1);
            repeat (2) @(negedge clk);
            chk("R8 valid held", data_valid, 1);
        end

        // R5/R6 random armed starts
        for (int i = 0; i < 20; i++) begin
            logic [2:0] sa, sb;
            bit chg;
            int w;
            sa = 3'($urandom % 8);
            sb = ($urandom % 2) ? sa : 3'($urandom % 8);
            chg = (sa != sb);
            frame(1'b0, sa, 1'b1);
            frame(1'b1, sb, 1'b1);
            w = (chg ? ST : 0) + int'($urandom % 5);
            repeat (w) @(negedge clk);
            chk("R5 armed tracking", track_o, 1);
            chk("R5 no cal before edge", cal_o, 0);
            sync_pin = 1'b1;
            run_len(t, c, v);
            chk("R6 sync latency", t, 3);
            chk("R6 cal length", c, CA);
            chk("R6 conv length", v, CV);
            chk("R8 valid after armed", data_valid, 1);
            sync_pin = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R7 edge inside settling is masked
        frame(1'b0, 3'd0, 1'b1);
        frame(1'b1, 3'd5, 1'b1);
        sync_pin = 1'b1;
        repeat (ST + 10) @(negedge clk);
        chk("R7 masked edge still armed", track_o, 1);
        chk("R7 masked edge no cal", cal_o, 0);
        sync_pin = 1'b0;
        repeat (3) @(negedge clk);
        sync_pin = 1'b1;
        run_len(t, c, v);
        chk("R7 next edge latency", t, 3);
        chk("R7 next edge conv", v, CV);
        sync_pin = 1'b0;
        repeat (3) @(negedge clk);

        // R9 abort armed wait; R4 held start bit
        frame(1'b0, 3'd1, 1'b1);
        frame(1'b1, 3'd1, 1'b1);
        repeat (40) @(negedge clk);
        chk("R5 long armed", {track_o, cal_o}, 2);
        adc_en = 1'b0;
        @(negedge clk);
        chk("R9 abort armed", {track_o, cal_o, conv_o}, 0);
        adc_en = 1'b1;
        frame(1'b1, 3'd1, 1'b0);
        repeat (5) @(negedge clk);
        chk("R4 held start bit", {track_o, cal_o, conv_o}, 0);

        // R4 start bit change without strobe
        frame(1'b0, 3'd1, 1'b0);
        start_bit = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 no strobe", {track_o, cal_o, conv_o}, 0);

        // R9 abort during calibration
        frame(1'b0, 3'd2, 1'b0);
        frame(1'b1, 3'd2, 1'b0);
        repeat (TR + 2) @(negedge clk);
        chk("R9 in cal", cal_o, 1);
        adc_en = 1'b0;
        @(negedge clk);
        chk("R9 abort cal", {track_o, cal_o, conv_o}, 0);
        chk("R9 valid stays clear", data_valid, 0);
        frame(1'b0, 3'd2, 1'b0);
        frame(1'b1, 3'd2, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 no start while disabled", track_o, 0);
        adc_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R9 stays idle", {track_o, cal_o, conv_o}, 0);

        // R4 start edge while busy is ignored
        frame(1'b0, 3'd2, 1'b0);
        frame(1'b1, 3'd2, 1'b0);
        repeat (TR + CA + 2) @(negedge clk);
        chk("R4 in conv", conv_o, 1);
        frame(1'b0, 3'd2, 1'b0);
        frame(1'b1, 3'd2, 1'b0);
        repeat (CV) @(negedge clk);
        chk("R4 busy start ignored", {track_o, cal_o, conv_o}, 0);
        chk("R4 busy valid", data_valid, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule